// File: doc/BRIEF.md
# Low Power Entry Sequencer

This block decides when the system tries to enter low power and how each attempt ends. Software arms it by setting a low-power hint and choosing which wake and reset sources may end a sleep. Those settings cross into the slow controller clock domain only when software sets a sync bit. The sync bit stays high until a request/acknowledge handshake has completed, and then it clears by itself.

In the slow domain, a four-state controller (active, entry check, low power, exit) samples the CPU sleeping signal together with the synchronized hint. An attempt runs through a fixed check window. During that window a pending interrupt causes a fall-through exit, and a busy non-volatile transaction causes an abort. If neither occurs, the controller asserts power-down and clock-gate requests. It stays in low power until an enabled wake or reset request arrives.

Every exit produces a one-cycle strobe that carries a two-bit cause code. Every exit also clears the hint. That clear is returned to the software domain, so software can poll the hint to learn that the exit has fully propagated.

Top module: `lp_seq_top`

## Requirements
- R1: An attempt starts only at a slow-clock edge that samples both the synchronized hint and `cpu_sleeping_i` high. The check window then lasts CHK_CYC (default 4) further edges. `pd_req_o` and `clk_gate_o` rise at the CHK_CYC-th edge after the sampling edge, if no exit condition was seen.
- R2: A sleeping pulse that starts and ends between two slow-clock edges causes no attempt. No exit strobe appears, `pd_req_o` stays low and `hint_o` keeps its value.
- R3: An interrupt pending at any edge of the check window ends the attempt with cause code 2'b10 (fall-through). `pd_req_o` is never asserted.
- R4: A busy non-volatile transaction at any edge of the check window ends the attempt with cause code 2'b11 (abort). `pd_req_o` is never asserted. Abort takes priority over fall-through at the same edge.
- R5: In low power, an enabled wake request exits with code 2'b00 and an enabled reset request exits with code 2'b01. When both are present, the reset exit wins.
- R6: A wake or reset request whose bit is clear in its enable mask is ignored. The controller remains in low power with `pd_req_o` high.
- R7: Hint and enable writes have no effect on the controller until `sync_req_i` is pulsed. `sync_busy_o` reads 1 from the cycle after that pulse until the handshake completes, and then returns to 0 by itself.
- R8: `exit_valid_o` is high for exactly one slow-clock cycle, with the cause on `exit_cause_o`. `pd_req_o` is low during the strobe, and `active_o` is high in the following cycle.
- R9: Every exit clears the controller's hint, so a CPU that stays asleep does not start a new attempt. `hint_o` reads 0 once the clear has crossed back to the software domain.
- R10: After reset, `pd_req_o`, `clk_gate_o`, `exit_valid_o`, `sync_busy_o` and `hint_o` are 0, and `active_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sw | input | 1 | Software-side register clock |
| rst_sw | input | 1 | Synchronous active-high reset, software side |
| clk_lp | input | 1 | Slow controller clock |
| rst_lp | input | 1 | Synchronous active-high reset, controller side |
| hint_wr_i | input | 1 | Write strobe for the hint register |
| hint_wdata_i | input | 1 | Value written to the hint register |
| wake_en_i | input | NUM_WAKE | Wake source enable mask (staged) |
| rst_en_i | input | NUM_RST | Reset source enable mask (staged) |
| sync_req_i | input | 1 | Pulse that starts a configuration transfer |
| hint_o | output | 1 | Hint register readback |
| sync_busy_o | output | 1 | Sync bit readback, high while a transfer is in flight |
| cpu_sleeping_i | input | 1 | CPU sleeping indication |
| irq_pending_i | input | 1 | An unmasked interrupt is pending |
| nvm_busy_i | input | 1 | Non-volatile memory transaction in progress |
| wake_req_i | input | NUM_WAKE | Wake requests, one per source |
| rst_req_i | input | NUM_RST | Reset requests, one per source |
| pd_req_o | output | 1 | Power-down request |
| clk_gate_o | output | 1 | Clock-gate request |
| active_o | output | 1 | Controller is in the active state |
| exit_valid_o | output | 1 | One-cycle exit strobe |
| exit_cause_o | output | 2 | Exit cause, valid with the strobe |

## Verification
The assertions assume three things about the inputs:
- Sleeping, interrupt, busy and request inputs are already synchronous to `clk_lp`.
- Software does not rewrite the hint or the enable masks while `sync_busy_o` is high.
- A hardware hint clear never coincides with a software hint write.

The stimulus drives every controller-side input on the falling edge of `clk_lp`, and every software-side input on the falling edge of `clk_sw`. The one deliberate exception is the short sleeping pulse, which is timed to rise and fall between two rising edges. Configuration is changed only through a task that waits for the sync bit to clear before it returns.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_CHECK  = 2'd1,
    ST_LOWPWR = 2'd2,
    ST_EXIT   = 2'd3
  } lp_state_e;

  typedef enum logic [1:0] {
    CAUSE_WAKE  = 2'b00,
    CAUSE_RESET = 2'b01,
    CAUSE_FALL  = 2'b10,
    CAUSE_ABORT = 2'b11
  } exit_cause_e;

endpackage

// File: rtl/lp_sync2.sv
module lp_sync2 #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d};
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/lp_cfg_cdc.sv
module lp_cfg_cdc #(
  parameter int NW = 2,
  parameter int NR = 2
) (
  input  logic          clk_sw,
  input  logic          rst_sw,
  input  logic          clk_lp,
  input  logic          rst_lp,
  input  logic          hint_wr_i,
  input  logic          hint_wdata_i,
  input  logic [NW-1:0] wake_en_i,
  input  logic [NR-1:0] rst_en_i,
  input  logic          sync_req_i,
  output logic          sync_busy_o,
  output logic          hint_o,
  input  logic          lp_exit_i,
  output logic          lp_hint_o,
  output logic [NW-1:0] lp_wake_en_o,
  output logic [NR-1:0] lp_rst_en_o
);

  // software domain
  logic          req_q;
  logic          ack_sw;
  logic          tgl_sw;
  logic          tgl_sw_d;
  logic          hint_q;
  logic          sh_hint;
  logic [NW-1:0] sh_wake;
  logic [NR-1:0] sh_rst;

  // controller domain
  logic          req_lp;
  logic          req_lp_d;
  logic          ack_lp;
  logic          tgl_lp;
  logic          lp_hint_q;
  logic [NW-1:0] lp_wake_q;
  logic [NR-1:0] lp_rst_q;
  logic          capture;

  lp_sync2 #(.W(1), .STAGES(2)) u_ack_sync (
    .clk (clk_sw),
    .rst (rst_sw),
    .d   (ack_lp),
    .q   (ack_sw)
  );

  lp_sync2 #(.W(1), .STAGES(2)) u_tgl_sync (
    .clk (clk_sw),
    .rst (rst_sw),
    .d   (tgl_lp),
    .q   (tgl_sw)
  );

  lp_sync2 #(.W(1), .STAGES(2)) u_req_sync (
    .clk (clk_lp),
    .rst (rst_lp),
    .d   (req_q),
    .q   (req_lp)
  );

  assign sync_busy_o = req_q | ack_sw;
  assign hint_o      = hint_q;

  always_ff @(posedge clk_sw) begin
    if (rst_sw) begin
      req_q    <= 1'b0;
      tgl_sw_d <= 1'b0;
      hint_q   <= 1'b0;
      sh_hint  <= 1'b0;
      sh_wake  <= '0;
      sh_rst   <= '0;
    end else begin
      tgl_sw_d <= tgl_sw;
      if (hint_wr_i) begin
        hint_q <= hint_wdata_i;
      end else if (tgl_sw ^ tgl_sw_d) begin
        hint_q <= 1'b0;
      end
      if (sync_req_i && !sync_busy_o) begin
        req_q   <= 1'b1;
        sh_hint <= hint_q;
        sh_wake <= wake_en_i;
        sh_rst  <= rst_en_i;
      end else if (ack_sw) begin
        req_q <= 1'b0;
      end
    end
  end

  assign capture = req_lp & ~req_lp_d;

  always_ff @(posedge clk_lp) begin
    if (rst_lp) begin
      req_lp_d  <= 1'b0;
      ack_lp    <= 1'b0;
      tgl_lp    <= 1'b0;
      lp_hint_q <= 1'b0;
      lp_wake_q <= '0;
      lp_rst_q  <= '0;
    end else begin
      req_lp_d <= req_lp;
      ack_lp   <= req_lp;
      if (lp_exit_i) begin
        tgl_lp <= ~tgl_lp;
      end
      if (capture) begin
        lp_wake_q <= sh_wake;
        lp_rst_q  <= sh_rst;
      end
      if (lp_exit_i) begin
        lp_hint_q <= 1'b0;
      end else if (capture) begin
        lp_hint_q <= sh_hint;
      end
    end
  end

  assign lp_hint_o    = lp_hint_q;
  assign lp_wake_en_o = lp_wake_q;
  assign lp_rst_en_o  = lp_rst_q;

  AST_BUSY_HELD: assert property (@(posedge clk_sw) disable iff (rst_sw)
    (req_q && !ack_sw) |=> req_q); // R7

  AST_SHADOW_STABLE: assert property (@(posedge clk_sw) disable iff (rst_sw)
    (req_q && $past(req_q)) |-> ($stable(sh_hint) && $stable(sh_wake) && $stable(sh_rst))); // R7

  AST_HINT_DROPPED: assert property (@(posedge clk_lp) disable iff (rst_lp)
    lp_exit_i |=> !lp_hint_q); // R9

endmodule

// File: rtl/lp_entry_fsm.sv
module lp_entry_fsm
  import lp_seq_pkg::*;
#(
  parameter int NW      = 2,
  parameter int NR      = 2,
  parameter int CHK_CYC = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hint_i,
  input  logic [NW-1:0] wake_en_i,
  input  logic [NR-1:0] rst_en_i,
  input  logic          cpu_sleeping_i,
  input  logic          irq_pending_i,
  input  logic          nvm_busy_i,
  input  logic [NW-1:0] wake_req_i,
  input  logic [NR-1:0] rst_req_i,
  output logic          pd_req_o,
  output logic          clk_gate_o,
  output logic          active_o,
  output logic          exit_valid_o,
  output logic [1:0]    exit_cause_o,
  output logic          exit_evt_o
);

  localparam int CW = (CHK_CYC > 1) ? $clog2(CHK_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CHK_CYC - 1);

  lp_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  exit_cause_e cause_d;
  logic        wake_hit;
  logic        rst_hit;

  logic        pd_q;
  logic        gate_q;
  logic        act_q;
  logic        exv_q;
  logic [1:0]  cause_q;

  assign wake_hit = |(wake_req_i & wake_en_i);
  assign rst_hit  = |(rst_req_i & rst_en_i);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cause_d = CAUSE_WAKE;
    unique case (state_q)
      ST_ACTIVE: begin
        if (hint_i && cpu_sleeping_i) begin
          state_d = ST_CHECK;
          cnt_d   = '0;
        end
      end
      ST_CHECK: begin
        if (nvm_busy_i) begin
          state_d = ST_EXIT;
          cause_d = CAUSE_ABORT;
        end else if (irq_pending_i) begin
          state_d = ST_EXIT;
          cause_d = CAUSE_FALL;
        end else if (cnt_q == LAST) begin
          state_d = ST_LOWPWR;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_LOWPWR: begin
        if (rst_hit) begin
          state_d = ST_EXIT;
          cause_d = CAUSE_RESET;
        end else if (wake_hit) begin
          state_d = ST_EXIT;
          cause_d = CAUSE_WAKE;
        end
      end
      ST_EXIT: begin
        state_d = ST_ACTIVE;
      end
      default: begin
        state_d = ST_ACTIVE;
      end
    endcase
  end

  assign exit_evt_o = (state_d == ST_EXIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ACTIVE;
      cnt_q   <= '0;
      pd_q    <= 1'b0;
      gate_q  <= 1'b0;
      act_q   <= 1'b1;
      exv_q   <= 1'b0;
      cause_q <= 2'b00;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pd_q    <= (state_d == ST_LOWPWR);
      gate_q  <= (state_d == ST_LOWPWR);
      act_q   <= (state_d == ST_ACTIVE);
      exv_q   <= (state_d == ST_EXIT);
      if (state_d == ST_EXIT) begin
        cause_q <= cause_d;
      end
    end
  end

  assign pd_req_o     = pd_q;
  assign clk_gate_o   = gate_q;
  assign active_o     = act_q;
  assign exit_valid_o = exv_q;
  assign exit_cause_o = cause_q;

  AST_NO_SLEEP_NO_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACTIVE && !(hint_i && cpu_sleeping_i)) |=> (state_q == ST_ACTIVE)); // R2

  AST_PD_AFTER_CHECK: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_req_o) |-> ($past(state_q) == ST_CHECK)); // R1

  AST_FALL_NO_PD: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CHECK && irq_pending_i && !nvm_busy_i) |=> (!pd_req_o && exit_valid_o && exit_cause_o == 2'b10)); // R3

  AST_ABORT_WINS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CHECK && nvm_busy_i) |=> (!pd_req_o && exit_valid_o && exit_cause_o == 2'b11)); // R4

  AST_RESET_WINS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOWPWR && rst_hit) |=> (exit_valid_o && exit_cause_o == 2'b01)); // R5

  AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOWPWR && !wake_hit && !rst_hit) |=> pd_req_o); // R6

  AST_EXIT_PULSE: assert property (@(posedge clk) disable iff (rst)
    exit_valid_o |=> (!exit_valid_o && active_o)); // R8

endmodule

// File: rtl/lp_seq_top.sv
module lp_seq_top #(
  parameter int NUM_WAKE = 2,
  parameter int NUM_RST  = 2,
  parameter int CHK_CYC  = 4
) (
  input  logic                clk_sw,
  input  logic                rst_sw,
  input  logic                clk_lp,
  input  logic                rst_lp,
  input  logic                hint_wr_i,
  input  logic                hint_wdata_i,
  input  logic [NUM_WAKE-1:0] wake_en_i,
  input  logic [NUM_RST-1:0]  rst_en_i,
  input  logic                sync_req_i,
  output logic                hint_o,
  output logic                sync_busy_o,
  input  logic                cpu_sleeping_i,
  input  logic                irq_pending_i,
  input  logic                nvm_busy_i,
  input  logic [NUM_WAKE-1:0] wake_req_i,
  input  logic [NUM_RST-1:0]  rst_req_i,
  output logic                pd_req_o,
  output logic                clk_gate_o,
  output logic                active_o,
  output logic                exit_valid_o,
  output logic [1:0]          exit_cause_o
);

  logic                lp_hint;
  logic [NUM_WAKE-1:0] lp_wake_en;
  logic [NUM_RST-1:0]  lp_rst_en;
  logic                exit_evt;

  lp_cfg_cdc #(.NW(NUM_WAKE), .NR(NUM_RST)) u_cdc (
    .clk_sw       (clk_sw),
    .rst_sw       (rst_sw),
    .clk_lp       (clk_lp),
    .rst_lp       (rst_lp),
    .hint_wr_i    (hint_wr_i),
    .hint_wdata_i (hint_wdata_i),
    .wake_en_i    (wake_en_i),
    .rst_en_i     (rst_en_i),
    .sync_req_i   (sync_req_i),
    .sync_busy_o  (sync_busy_o),
    .hint_o       (hint_o),
    .lp_exit_i    (exit_evt),
    .lp_hint_o    (lp_hint),
    .lp_wake_en_o (lp_wake_en),
    .lp_rst_en_o  (lp_rst_en)
  );

  lp_entry_fsm #(.NW(NUM_WAKE), .NR(NUM_RST), .CHK_CYC(CHK_CYC)) u_fsm (
    .clk            (clk_lp),
    .rst            (rst_lp),
    .hint_i         (lp_hint),
    .wake_en_i      (lp_wake_en),
    .rst_en_i       (lp_rst_en),
    .cpu_sleeping_i (cpu_sleeping_i),
    .irq_pending_i  (irq_pending_i),
    .nvm_busy_i     (nvm_busy_i),
    .wake_req_i     (wake_req_i),
    .rst_req_i      (rst_req_i),
    .pd_req_o       (pd_req_o),
    .clk_gate_o     (clk_gate_o),
    .active_o       (active_o),
    .exit_valid_o   (exit_valid_o),
    .exit_cause_o   (exit_cause_o),
    .exit_evt_o     (exit_evt)
  );

endmodule

// File: tb/tb_lp_seq_top.sv
module tb_lp_seq_top;

  localparam int CLK_PERIOD = 10;
  localparam int LP_PERIOD  = 4 * CLK_PERIOD;
  localparam int NW = 2;
  localparam int NR = 2;

  logic clk_sw = 1'b0;
  logic clk_lp = 1'b0;
  logic rst_sw = 1'b1;
  logic rst_lp = 1'b1;
  logic hint_wr_i = 1'b0;
  logic hint_wdata_i = 1'b0;
  logic [NW-1:0] wake_en_i = '0;
  logic [NR-1:0] rst_en_i = '0;
  logic sync_req_i = 1'b0;
  logic hint_o;
  logic sync_busy_o;
  logic cpu_sleeping_i = 1'b0;
  logic irq_pending_i = 1'b0;
  logic nvm_busy_i = 1'b0;
  logic [NW-1:0] wake_req_i = '0;
  logic [NR-1:0] rst_req_i = '0;
  logic pd_req_o;
  logic clk_gate_o;
  logic active_o;
  logic exit_valid_o;
  logic [1:0] exit_cause_o;

  int n_vec = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk_sw = ~clk_sw;
  always #(LP_PERIOD/2)  clk_lp = ~clk_lp;

  lp_seq_top #(.NUM_WAKE(NW), .NUM_RST(NR), .CHK_CYC(4)) dut (
    .clk_sw         (clk_sw),
    .rst_sw         (rst_sw),
    .clk_lp         (clk_lp),
    .rst_lp         (rst_lp),
    .hint_wr_i      (hint_wr_i),
    .hint_wdata_i   (hint_wdata_i),
    .wake_en_i      (wake_en_i),
    .rst_en_i       (rst_en_i),
    .sync_req_i     (sync_req_i),
    .hint_o         (hint_o),
    .sync_busy_o    (sync_busy_o),
    .cpu_sleeping_i (cpu_sleeping_i),
    .irq_pending_i  (irq_pending_i),
    .nvm_busy_i     (nvm_busy_i),
    .wake_req_i     (wake_req_i),
    .rst_req_i      (rst_req_i),
    .pd_req_o       (pd_req_o),
    .clk_gate_o     (clk_gate_o),
    .active_o       (active_o),
    .exit_valid_o   (exit_valid_o),
    .exit_cause_o   (exit_cause_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string cause_req(input logic [1:0] c);
    case (c)
      2'b10:   return "R3";
      2'b11:   return "R4";
      default: return "R5";
    endcase
  endfunction

  // monitor: pops the expected exit cause on each strobe
  always @(negedge clk_lp) begin
    if (!rst_lp && exit_valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected exit strobe", int'(exit_cause_o), -1);
      end else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        check(exit_cause_o == e, cause_req(e), int'(exit_cause_o), int'(e));
      end
    end
  end

  task automatic lp_cyc(input int n);
    repeat (n) @(negedge clk_lp);
  endtask

  task automatic do_sync(input bit h, input logic [NW-1:0] we, input logic [NR-1:0] re);
    bit cleared;
    @(negedge clk_sw);
    hint_wr_i = 1'b1; hint_wdata_i = h; wake_en_i = we; rst_en_i = re;
    @(negedge clk_sw);
    hint_wr_i = 1'b0; sync_req_i = 1'b1;
    @(negedge clk_sw);
    sync_req_i = 1'b0;
    check(sync_busy_o == 1'b1, "R7 sync bit set", int'(sync_busy_o), 1);
    cleared = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_sw);
      if (!sync_busy_o) begin
        cleared = 1'b1;
        break;
      end
    end
    check(cleared, "R7 sync bit self-clears", int'(sync_busy_o), 0);
  endtask

  task automatic enter_lp();
    @(negedge clk_lp);
    cpu_sleeping_i = 1'b1;
    lp_cyc(4);
    check(pd_req_o == 1'b0, "R1 no power-down inside check window", int'(pd_req_o), 0);
    @(negedge clk_lp);
    check(pd_req_o == 1'b1, "R1 power-down after check window", int'(pd_req_o), 1);
    check(clk_gate_o == 1'b1, "R1 clock gate after check window", int'(clk_gate_o), 1);
    cpu_sleeping_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk_lp);
    @(negedge clk_lp);
    rst_sw = 1'b0;
    rst_lp = 1'b0;
    @(negedge clk_lp);
    check(pd_req_o == 1'b0, "R10 pd after reset", int'(pd_req_o), 0);
    check(clk_gate_o == 1'b0, "R10 gate after reset", int'(clk_gate_o), 0);
    check(exit_valid_o == 1'b0, "R10 strobe after reset", int'(exit_valid_o), 0);
    check(active_o == 1'b1, "R10 active after reset", int'(active_o), 1);
    check(sync_busy_o == 1'b0, "R10 sync bit after reset", int'(sync_busy_o), 0);
    check(hint_o == 1'b0, "R10 hint after reset", int'(hint_o), 0);

    // R7: hint written but never synced has no effect
    @(negedge clk_sw);
    hint_wr_i = 1'b1; hint_wdata_i = 1'b1;
    @(negedge clk_sw);
    hint_wr_i = 1'b0;
    @(negedge clk_lp);
    cpu_sleeping_i = 1'b1;
    lp_cyc(8);
    check(pd_req_o == 1'b0, "R7 unsynced hint ignored", int'(pd_req_o), 0);
    check(active_o == 1'b1, "R7 still active", int'(active_o), 1);
    cpu_sleeping_i = 1'b0;
    lp_cyc(1);
    check(hint_o == 1'b1, "R7 hint readback kept", int'(hint_o), 1);

    // R2: short sleeping pulse between edges
    do_sync(1'b1, 2'b01, 2'b01);
    @(posedge clk_lp);
    #(LP_PERIOD/8) cpu_sleeping_i = 1'b1;
    #(LP_PERIOD/4) cpu_sleeping_i = 1'b0;
    lp_cyc(8);
    check(pd_req_o == 1'b0, "R2 short pulse no power-down", int'(pd_req_o), 0);
    check(active_o == 1'b1, "R2 short pulse stays active", int'(active_o), 1);
    check(hint_o == 1'b1, "R2 short pulse hint kept", int'(hint_o), 1);

    // R1/R6/R5/R8/R9: graceful wake
    enter_lp();
    wake_req_i = 2'b10; rst_req_i = 2'b10;
    lp_cyc(3);
    check(pd_req_o == 1'b1, "R6 masked requests ignored", int'(pd_req_o), 1);
    check(exit_valid_o == 1'b0, "R6 no strobe on masked requests", int'(exit_valid_o), 0);
    wake_req_i = '0; rst_req_i = '0;
    exp_q.push_back(2'b00);
    wake_req_i = 2'b01;
    @(negedge clk_lp);
    check(exit_valid_o == 1'b1, "R5 wake exit strobe", int'(exit_valid_o), 1);
    check(pd_req_o == 1'b0, "R8 pd low during strobe", int'(pd_req_o), 0);
    wake_req_i = '0;
    @(negedge clk_lp);
    check(exit_valid_o == 1'b0, "R8 strobe one cycle", int'(exit_valid_o), 0);
    check(active_o == 1'b1, "R8 active after exit", int'(active_o), 1);
    lp_cyc(4);
    check(hint_o == 1'b0, "R9 hint cleared after wake", int'(hint_o), 0);

    // R3 + R9: fall-through, sleeping kept high afterwards
    do_sync(1'b1, 2'b01, 2'b01);
    exp_q.push_back(2'b10);
    @(negedge clk_lp);
    cpu_sleeping_i = 1'b1; irq_pending_i = 1'b1;
    lp_cyc(2);
    check(exit_valid_o == 1'b1, "R3 fall-through strobe", int'(exit_valid_o), 1);
    check(pd_req_o == 1'b0, "R3 no power-down", int'(pd_req_o), 0);
    irq_pending_i = 1'b0;
    lp_cyc(6);
    check(active_o == 1'b1, "R9 no re-entry while asleep", int'(active_o), 1);
    check(hint_o == 1'b0, "R9 hint cleared after fall-through", int'(hint_o), 0);
    cpu_sleeping_i = 1'b0;

    // R4: abort wins over interrupt
    do_sync(1'b1, 2'b01, 2'b01);
    exp_q.push_back(2'b11);
    @(negedge clk_lp);
    cpu_sleeping_i = 1'b1; irq_pending_i = 1'b1; nvm_busy_i = 1'b1;
    lp_cyc(2);
    check(exit_valid_o == 1'b1, "R4 abort strobe", int'(exit_valid_o), 1);
    check(pd_req_o == 1'b0, "R4 no power-down", int'(pd_req_o), 0);
    cpu_sleeping_i = 1'b0; irq_pending_i = 1'b0; nvm_busy_i = 1'b0;
    lp_cyc(4);

    // R4: late busy inside the window
    do_sync(1'b1, 2'b01, 2'b01);
    exp_q.push_back(2'b11);
    @(negedge clk_lp);
    cpu_sleeping_i = 1'b1;
    lp_cyc(3);
    nvm_busy_i = 1'b1;
    @(negedge clk_lp);
    check(exit_valid_o == 1'b1, "R4 late abort strobe", int'(exit_valid_o), 1);
    cpu_sleeping_i = 1'b0; nvm_busy_i = 1'b0;
    lp_cyc(4);

    // R5: reset wins over wake
    do_sync(1'b1, 2'b01, 2'b01);
    enter_lp();
    exp_q.push_back(2'b01);
    wake_req_i = 2'b01; rst_req_i = 2'b01;
    @(negedge clk_lp);
    check(exit_valid_o == 1'b1, "R5 reset exit strobe", int'(exit_valid_o), 1);
    wake_req_i = '0; rst_req_i = '0;
    lp_cyc(4);

    check(exp_q.size() == 0, "R8 every expected exit seen", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk_sw);
    if (!done) begin
      n_vec++;
      n_err++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

endmodule